// File: doc/BRIEF.md
# Golomb Run-Length Scan Decompressor

This block turns a serial stream of Golomb code words into the bit stream that fills a scan chain. A code word is a group prefix (a row of 1s closed by a 0) followed by a fixed-width tail. The number of 1s in the prefix selects the group, and the tail selects a member inside that group. Each code word expands into a run of 0s closed by a single 1. The group size is a power-of-two parameter, so the tail width is its base-two logarithm.

Compressed bits enter one per cycle under a valid/ready handshake. While a run is being expanded the block withholds ready, so the tester side stalls. Because code words vary in length, this stall is what keeps the tester and the decoder in step. Decoded bits leave one per cycle, each marked by a valid strobe, with no back-pressure from the scan side.

An elaboration option adds a circular reference register that is one pattern long. When the option is on, each decoded bit is XORed with the output bit that left exactly one pattern earlier. The stream is then read as difference vectors, and the block rebuilds the actual test cubes from them.

Top module: `golomb_scan_dec`

## Requirements
- R1: A synchronous reset puts the block in prefix counting with group zero and clears the reference register. In the cycle after a reset edge, `in_ready` is 1 and `out_valid` is 0.
- R2: A code word consists of q 1s, then a 0, then a tail of log2(GROUP_M) bits sent most significant bit first. It decodes to exactly q*GROUP_M + tail 0s followed by one 1. With GROUP_M = 4, the word 010 gives 001 and the word 1010 gives 0000001.
- R3: `in_ready` is 0 in every cycle in which `out_valid` is 1. A bit presented while `in_ready` is 0 is not consumed, and it is used unchanged once `in_ready` returns.
- R4: `out_valid` first rises in the cycle right after the last tail bit is accepted. From then on, one decoded bit leaves in every cycle with no gap until the closing 1.
- R5: A cycle with `in_valid` at 0 leaves the decoder state unchanged, whatever `in_bit` holds. This applies inside a code word as well as between code words.
- R6: A tail of zero gives a run made only of whole groups, and the word with an empty prefix and a zero tail gives a lone 1.
- R7: With DIFF_EN = 1, each output bit is the decoded bit XOR the output bit sent PAT_LEN valid outputs earlier. That earlier bit counts as 0 until PAT_LEN bits have left since reset.
- R8: With DIFF_EN = 0, the output bit is the decoded bit itself.
- R9: A reset during a run abandons that run. The first code word after the reset is decoded against a cleared reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Compressed bit is present |
| in_ready | output | 1 | Decoder can accept a compressed bit |
| in_bit | input | 1 | Compressed bit |
| out_valid | output | 1 | Decoded scan bit is present |
| out_bit | output | 1 | Decoded (or reconstructed) scan bit |

## Verification
A compressed bit counts as accepted at the rising edge where both `in_valid` and `in_ready` are high. The first decoded bit of a word is due one cycle after the edge that took its last tail bit. After that, a decoded bit is due in every following cycle, and `in_ready` comes back high in the cycle after the closing 1. The bench changes inputs on falling edges. On every falling edge it captures and checks both outputs and ready. It checks `out_valid` on the falling edge that directly follows the acceptance of a last tail bit, and it compares the captured stream with a bit list built from the code words alone. The difference-mode stream is predicted by folding the expected output from one pattern earlier into each decoded bit.

// File: rtl/golomb_dec_pkg.sv
package golomb_dec_pkg;
   typedef enum logic [1:0] {
      ST_PREFIX = 2'd0,
      ST_TAIL   = 2'd1,
      ST_RUN    = 2'd2
   } dec_state_e;
endpackage

// File: rtl/golomb_word_parse.sv
// Parses unary group prefix and binary tail; loads the run length on the last code bit.
module golomb_word_parse
   import golomb_dec_pkg::*;
#(
   parameter int GROUP_M = 4,
   parameter int GRP_W   = 6,
   localparam int TAIL_W  = $clog2(GROUP_M),
   localparam int LEN_W   = GRP_W + TAIL_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             take,
   input  logic             code_bit,
   input  logic             run_done,
   output dec_state_e       state,
   output logic             load,
   output logic [LEN_W-1:0] load_len
);
   localparam int  TAIL_RW  = (TAIL_W > 0) ? TAIL_W : 1;
   localparam int  TCNT_W   = $clog2(TAIL_RW + 1);
   localparam bit  HAS_TAIL = (TAIL_W > 0);

   logic [GRP_W-1:0]   grp;
   logic [TAIL_RW-1:0] tail;
   logic [TAIL_RW-1:0] tail_nx;
   logic [TCNT_W-1:0]  tcnt;

   assign tail_nx = TAIL_RW'({tail, code_bit});

   generate
      if (HAS_TAIL) begin : g_tail
         assign load     = take && (state == ST_TAIL) && (tcnt == TCNT_W'(TAIL_W - 1));
         assign load_len = LEN_W'({grp, tail_nx});
      end else begin : g_no_tail
         assign load     = take && (state == ST_PREFIX) && !code_bit;
         assign load_len = LEN_W'(grp);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_PREFIX;
         grp   <= '0;
         tail  <= '0;
         tcnt  <= '0;
      end else begin
         case (state)
            ST_PREFIX: begin
               if (take) begin
                  if (code_bit) begin
                     if (grp != '1) grp <= grp + GRP_W'(1);
                  end else if (!HAS_TAIL) begin
                     state <= ST_RUN;
                  end else begin
                     state <= ST_TAIL;
                     tail  <= '0;
                     tcnt  <= '0;
                  end
               end
            end
            ST_TAIL: begin
               if (take) begin
                  tail <= tail_nx;
                  tcnt <= tcnt + TCNT_W'(1);
                  if (load) state <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (run_done) begin
                  state <= ST_PREFIX;
                  grp   <= '0;
               end
            end
            default: state <= ST_PREFIX;
         endcase
      end
   end
endmodule

// File: rtl/golomb_run_expand.sv
// Down-counter that emits the 0s of a run and flags the closing 1.
module golomb_run_expand #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [LEN_W-1:0] load_len,
   input  logic             active,
   output logic             last
);
   logic [LEN_W-1:0] cnt;

   assign last = (cnt == '0);

   always_ff @(posedge clk) begin
      if (rst)                 cnt <= '0;
      else if (load)           cnt <= load_len;
      else if (active && !last) cnt <= cnt - LEN_W'(1);
   end
endmodule

// File: rtl/golomb_ref_xor.sv
// Optional difference-vector reconstruction against the previous pattern.
module golomb_ref_xor #(
   parameter int PAT_LEN = 8,
   parameter bit DIFF_EN = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic valid,
   input  logic dec_bit,
   output logic out_bit
);
   generate
      if (DIFF_EN) begin : g_diff
         logic [PAT_LEN-1:0] ref_sr;
         assign out_bit = dec_bit ^ ref_sr[PAT_LEN-1];
         always_ff @(posedge clk) begin
            if (rst)        ref_sr <= '0;
            else if (valid) ref_sr <= {ref_sr[PAT_LEN-2:0], out_bit};
         end
      end else begin : g_plain
         logic unused_ref;
         assign unused_ref = ^{clk, rst, valid};
         assign out_bit    = dec_bit;
      end
   endgenerate
endmodule

// File: rtl/golomb_scan_dec.sv
module golomb_scan_dec
   import golomb_dec_pkg::*;
#(
   parameter int GROUP_M = 4,
   parameter int GRP_W   = 6,
   parameter int PAT_LEN = 8,
   parameter bit DIFF_EN = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   output logic in_ready,
   input  logic in_bit,
   output logic out_valid,
   output logic out_bit
);
   localparam int TAIL_W = $clog2(GROUP_M);
   localparam int LEN_W  = GRP_W + TAIL_W;

   generate
      if (GROUP_M < 1 || (GROUP_M & (GROUP_M - 1)) != 0) begin : g_bad_m
         $error("GROUP_M must be a power of two");
      end
      if (PAT_LEN < 2) begin : g_bad_pat
         $error("PAT_LEN must be at least 2");
      end
      if (GRP_W < 1) begin : g_bad_grp
         $error("GRP_W must be at least 1");
      end
   endgenerate

   dec_state_e       state;
   logic             take;
   logic             load;
   logic [LEN_W-1:0] load_len;
   logic             run_active;
   logic             run_last;
   logic             run_done;

   assign run_active = (state == ST_RUN);
   assign in_ready   = !run_active;
   assign take       = in_valid && in_ready;
   assign run_done   = run_active && run_last;
   assign out_valid  = run_active;

   golomb_word_parse #(.GROUP_M(GROUP_M), .GRP_W(GRP_W)) u_parse (
      .clk(clk), .rst(rst), .take(take), .code_bit(in_bit), .run_done(run_done),
      .state(state), .load(load), .load_len(load_len)
   );

   golomb_run_expand #(.LEN_W(LEN_W)) u_run (
      .clk(clk), .rst(rst), .load(load), .load_len(load_len),
      .active(run_active), .last(run_last)
   );

   golomb_ref_xor #(.PAT_LEN(PAT_LEN), .DIFF_EN(DIFF_EN)) u_ref (
      .clk(clk), .rst(rst), .valid(run_active), .dec_bit(run_last), .out_bit(out_bit)
   );
endmodule

// File: rtl/golomb_scan_dec_chk.sv
module golomb_scan_dec_chk #(
   parameter bit DIFF_EN = 1'b0
) (
   input logic clk,
   input logic rst,
   input logic in_valid,
   input logic in_ready,
   input logic out_valid,
   input logic out_bit
);
   // R1: reset leaves the block idle and ready
   a_r1_reset_idle: assert property (@(posedge clk) rst |=> (in_ready && !out_valid));

   // R3: the input is stalled while a run is expanded
   a_r3_stall_in_run: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !in_ready);

   // R5: without an input beat, no run can start
   a_r5_idle_no_start: assert property (@(posedge clk) disable iff (rst)
      (!in_valid && !out_valid) |=> !out_valid);

   // R4: a run starts only after an accepted code bit
   a_r4_start_after_beat: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> $past(in_valid && in_ready));

   generate
      if (!DIFF_EN) begin : g_plain
         // R2: a single 1 closes the run
         a_r2_one_closes_run: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_bit) |=> !out_valid);
         // R4: 0s are followed without gap by further output
         a_r4_no_gap: assert property (@(posedge clk) disable iff (rst)
            (out_valid && !out_bit) |=> out_valid);
      end
   endgenerate
endmodule

bind golomb_scan_dec golomb_scan_dec_chk #(.DIFF_EN(DIFF_EN)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_bit(out_bit)
);

// File: tb/sim_golomb_scan_dec.sv
`timescale 1ns/1ps
module sim_golomb_scan_dec;
   localparam int M  = 4;
   localparam int PL = 8;
   localparam int NV = 7;
   // [7:2] group count q, [1:0] tail
   localparam logic [7:0] VEC [NV] = '{8'h02, 8'h06, 8'h00, 8'h0B, 8'h03, 8'h0D, 8'h04};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic in_bit = 1'b0;
   logic rdy0, rdy1, o0_v, o0_b, o1_v, o1_b;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic e0 [256];
   logic e1 [256];
   logic c0 [256];
   logic c1 [256];
   int ne = 0;
   int oc = 0;

   always #10 clk = ~clk;

   golomb_scan_dec #(.GROUP_M(M), .GRP_W(6), .PAT_LEN(PL), .DIFF_EN(1'b0)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy0), .in_bit(in_bit),
      .out_valid(o0_v), .out_bit(o0_b));

   golomb_scan_dec #(.GROUP_M(M), .GRP_W(6), .PAT_LEN(PL), .DIFF_EN(1'b1)) u1 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy1), .in_bit(in_bit),
      .out_valid(o1_v), .out_bit(o1_b));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Output monitor, sampled on the falling edge
   always @(negedge clk) begin
      if (!rst && (o0_v || o1_v)) begin
         chk(!rdy0 && !rdy1, "R3 ready low while output valid", {rdy0, rdy1}, 0);
         chk(o0_v == o1_v, "R4 both instances valid together", o1_v, o0_v);
         if (oc < 256) begin
            c0[oc] = o0_b;
            c1[oc] = o1_b;
         end
         oc++;
      end
   end

   task automatic push_exp(input logic d);
      e0[ne] = d;
      e1[ne] = d ^ ((ne >= PL) ? e1[ne-PL] : 1'b0);
      ne++;
   endtask

   task automatic add_expect(input int q, input int t);
      for (int i = 0; i < q*M + t; i++) push_exp(1'b0);
      push_exp(1'b1);
   endtask

   // Called at a falling edge; returns at the falling edge after acceptance
   task automatic send_bit(input logic b, input bit last);
      logic r;
      in_valid = 1'b1;
      in_bit   = b;
      while (1) begin
         r = rdy0;
         @(negedge clk);
         if (r) break;
      end
      if (last) chk(o0_v && !rdy0, "R4 run starts one cycle after last tail bit", {o0_v, rdy0}, 2);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b0;
         in_bit   = ~in_bit;
         @(negedge clk);
      end
   endtask

   task automatic send_word(input int q, input int t, input bit bubble);
      for (int i = 0; i < q; i++) send_bit(1'b1, 1'b0);
      send_bit(1'b0, 1'b0);
      if (bubble) idle(2); // R5: idle beats inside a word
      send_bit(t[1], 1'b0);
      send_bit(t[0], 1'b1);
   endtask

   task automatic wait_out(input int n);
      int guard = 0;
      while (oc < n && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
   endtask

   task automatic compare_all(input string tag);
      chk(oc == ne, "R2 decoded bit count", oc, ne);
      for (int i = 0; i < ne && i < 256; i++) begin
         chk(c0[i] === e0[i], "R2/R8 plain output bit", int'(c0[i]), int'(e0[i]));
         chk(c1[i] === e1[i], "R7 difference output bit", int'(c1[i]), int'(e1[i]));
      end
      $display("%s: %0d bits compared", tag, ne);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R4 watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: state right after reset
      chk(rdy0 && rdy1, "R1 ready after reset", {rdy0, rdy1}, 3);
      chk(!o0_v && !o1_v, "R1 no output after reset", {o0_v, o1_v}, 0);

      // Vector table walk: R2, R3, R4, R5, R6, R7, R8
      for (int v = 0; v < NV; v++) begin
         add_expect(int'(VEC[v][7:2]), int'(VEC[v][1:0]));
         send_word(int'(VEC[v][7:2]), int'(VEC[v][1:0]), v[0]);
         if (v == 2) idle(3); // R5: idle beats between words
      end
      in_valid = 1'b0;
      wait_out(ne);
      compare_all("table");

      // R9: reset in the middle of a long run
      send_word(3, 3, 1'b0);
      in_valid = 1'b0;
      wait_out(oc + 3);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(rdy0 && !o0_v, "R9 reset abandons run", {rdy0, o0_v}, 2);
      chk(rdy1 && !o1_v, "R1 reset idle in difference instance", {rdy1, o1_v}, 2);
      @(posedge clk);
      oc = 0;
      ne = 0;
      @(negedge clk);
      // R6: lone 1 from empty prefix and zero tail; R9: cleared reference
      add_expect(0, 0);
      send_word(0, 0, 1'b0);
      add_expect(0, 1);
      send_word(0, 1, 1'b0);
      add_expect(2, 0); // R6: whole groups only
      send_word(2, 0, 1'b0);
      in_valid = 1'b0;
      wait_out(ne);
      compare_all("after reset");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule